// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time base into a programmable periodic tick for a real-time clock. The time base arrives as a one-cycle enable strobe on the system clock. The strobe advances a free-running 15-bit count. A 4-bit rate selector picks a power-of-two period. A tick occurs each time the count reaches a multiple of that period. Because of this, ticks stay phase-aligned to the count no matter when the rate or the enables change.

On a tick, the block can do two things. With the periodic-interrupt enable set, it emits a one-cycle periodic-flag set strobe toward the status register and raises a level interrupt request. The request stays high until the status logic acknowledges it. With the square-wave enable set, the square-wave output toggles on each tick. The block samples its control inputs on every clock, so a change to the rate or the enables takes effect on the very next strobe.

Top module: `rtc_rate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count goes to zero and `per_flag_set`, `irq_req` and `sq_out` go to 0.
- R2: With `rate_sel` = 0, no tick occurs: `per_flag_set` stays 0 and `sq_out` does not toggle.
- R3: For `rate_sel` from 3 to 15, the period is 2^(`rate_sel`-1) strobes of `tb32k_en`, giving 4 to 16384 strobes.
- R4: `rate_sel` = 1 gives the same period as 8 (128 strobes), and `rate_sel` = 2 gives the same period as 9 (256 strobes).
- R5: No tick occurs while both `per_irq_en` and `sq_en` are 0, whatever `rate_sel` is.
- R6: A tick occurs on the strobe that brings the count since reset (modulo 2^15) to a multiple of the period. After a change of `rate_sel`, the next tick lands on the next multiple of the new period.
- R7: On a tick with `per_irq_en` = 1, `per_flag_set` is high for exactly that one cycle. It appears in the cycle after the clock edge that samples the strobe.
- R8: A tick with `per_irq_en` = 1 sets `irq_req`. `irq_req` stays high until an `irq_ack` strobe clears it. If a setting tick and `irq_ack` fall on the same edge, the set wins.
- R9: With `sq_en` = 1, `sq_out` inverts on each tick. With `sq_en` = 0, it is held at 0 from the next edge on.
- R10: The count advances only on edges where `tb32k_en` is 1. Clock cycles without a strobe cause no tick and do not move the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb32k_en | input | 1 | One-cycle strobe at the 32768 Hz rate |
| rate_sel | input | 4 | Rate selector code |
| per_irq_en | input | 1 | Periodic interrupt enable |
| sq_en | input | 1 | Square-wave output enable |
| irq_ack | input | 1 | Strobe from the status logic that clears the interrupt request |
| per_flag_set | output | 1 | One-cycle strobe that sets the periodic status flag |
| irq_req | output | 1 | Level interrupt request |
| sq_out | output | 1 | Square-wave output |

## Verification
The main function is exercised by a sequence of rate and enable settings applied over one unbroken count. This covers short periods (4 and 8 strobes), the longest period (16384), the aliased codes 1 and 2 next to their twins 8 and 9, code 0, and both enables off. Because the count is never reset between settings, each switch shows whether the first tick after a change lands on a multiple of the new period rather than a full period after the change. The settings that enable only the interrupt, only the square wave, or both show that the two outputs gate independently. Directed steps with the strobe held low, and with an acknowledge placed on and off a tick, cover the phase hold and the set-over-clear priority.

// File: rtl/rtc_rate_pkg.sv
// Package: shared widths and constants for the periodic rate generator.
// Assumes a 15-bit divider and a 4-bit rate selector; the alias rule
// moves the two lowest nonzero codes up by a fixed offset.
package rtc_rate_pkg;
    localparam int RG_CNT_W     = 15;
    localparam int RG_CODE_W    = 4;
    localparam int RG_ALIAS_TOP = 2;   // highest code that is aliased
    localparam int RG_ALIAS_ADD = 7;   // offset applied to aliased codes
    localparam int RG_SHIFT_W   = $clog2(RG_CNT_W + 1);
endpackage

// File: rtl/rtc_rate_decode.sv
// Module: rtc_rate_decode
// Turns the rate selector into a low-bit mask of the period and decides
// whether the generator runs. Assumes codes 1..ALIAS_TOP alias upward by
// ALIAS_ADD and that the largest shift fits in CNT_W bits.
module rtc_rate_decode
    import rtc_rate_pkg::*;
#(
    parameter int CNT_W     = RG_CNT_W,
    parameter int CODE_W    = RG_CODE_W,
    parameter int ALIAS_TOP = RG_ALIAS_TOP,
    parameter int ALIAS_ADD = RG_ALIAS_ADD
) (
    input  logic [CODE_W-1:0] code,
    input  logic              irq_en,
    input  logic              sq_en,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    localparam int SHW = $clog2(CNT_W + 1);

    logic [SHW-1:0] shift;

    // Effective code after aliasing, then the log2 of the period.
    always_comb begin
        int eff;
        eff = int'(code);
        if (eff >= 1 && eff <= ALIAS_TOP) begin
            eff = eff + ALIAS_ADD;
        end
        if (eff == 0) begin
            shift = '0;
        end else begin
            shift = SHW'(eff - 1);
        end
    end

    // One mask bit per divider stage: set when the stage lies below the shift.
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (SHW'(g) < shift);
    end

    // Runs only with a nonzero code and at least one consumer enabled.
    assign active = (code != '0) && (irq_en || sq_en);
endmodule

// File: rtl/rtc_rate_divider.sv
// Module: rtc_rate_divider
// Free-running count of time-base strobes. Assumes the strobe is one
// system clock wide; the count wraps modulo 2^CNT_W.
module rtc_rate_divider #(
    parameter int CNT_W = rtc_rate_pkg::RG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    // Next value of the count on a strobe.
    assign cnt_nxt = cnt + CNT_W'(1);

    // Advance the count on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_nxt;
        end
    end

    // R10: without a strobe the count must not move.
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
endmodule

// File: rtl/rtc_rate_tick.sv
// Module: rtc_rate_tick
// Detects the strobe on which the low period bits of the count roll to
// zero. Assumes mask holds ones in exactly the low log2(period) bits.
module rtc_rate_tick #(
    parameter int CNT_W = rtc_rate_pkg::RG_CNT_W
) (
    input  logic             step,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] mask,
    output logic             tick
);
    // Tick when the new count is a multiple of the period.
    assign tick = step && active && ((cnt_nxt & mask) == '0);
endmodule

// File: rtl/rtc_rate_out.sv
// Module: rtc_rate_out
// Registers the flag strobe, the held interrupt request and the square
// wave from the tick. Assumes ticks are at least two strobes apart.
module rtc_rate_out (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic irq_en,
    input  logic sq_en,
    input  logic ack,
    output logic flag_set,
    output logic irq,
    output logic sq
);
    // One-cycle strobe toward the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_set <= 1'b0;
        else        flag_set <= tick && irq_en;
    end

    // Interrupt request: a tick sets it, an acknowledge clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (tick && irq_en)   irq <= 1'b1;
        else if (ack)              irq <= 1'b0;
    end

    // Square wave: toggles on ticks, forced low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       sq <= 1'b0;
        else if (!sq_en)  sq <= 1'b0;
        else if (tick)    sq <= ~sq;
    end

    // R7: the flag strobe never lasts two cycles.
    p_flag_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> !flag_set);
    // R8: the request holds until acknowledged.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    // R9: disabling the square wave drives it low.
    p_sq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |=> !sq);
endmodule

// File: rtl/rtc_rate_gen.sv
// Module: rtc_rate_gen (top)
// Periodic tick generator for a real-time clock: divides the 32768 Hz
// strobe by a power of two chosen by rate_sel and drives a flag strobe,
// an interrupt request and a square wave. Assumes inputs are synchronous
// to clk and that tb32k_en is a single-cycle strobe.
module rtc_rate_gen
    import rtc_rate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tb32k_en,
    input  logic [RG_CODE_W-1:0] rate_sel,
    input  logic                 per_irq_en,
    input  logic                 sq_en,
    input  logic                 irq_ack,
    output logic                 per_flag_set,
    output logic                 irq_req,
    output logic                 sq_out
);
    logic                active;
    logic [RG_CNT_W-1:0] mask;
    logic [RG_CNT_W-1:0] cnt;
    logic [RG_CNT_W-1:0] cnt_nxt;
    logic                tick;

    rtc_rate_decode #(
        .CNT_W     (RG_CNT_W),
        .CODE_W    (RG_CODE_W),
        .ALIAS_TOP (RG_ALIAS_TOP),
        .ALIAS_ADD (RG_ALIAS_ADD)
    ) u_decode (
        .code   (rate_sel),
        .irq_en (per_irq_en),
        .sq_en  (sq_en),
        .active (active),
        .mask   (mask)
    );

    rtc_rate_divider #(.CNT_W(RG_CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tb32k_en),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    rtc_rate_tick #(.CNT_W(RG_CNT_W)) u_tick (
        .step    (tb32k_en),
        .active  (active),
        .cnt_nxt (cnt_nxt),
        .mask    (mask),
        .tick    (tick)
    );

    rtc_rate_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .irq_en   (per_irq_en),
        .sq_en    (sq_en),
        .ack      (irq_ack),
        .flag_set (per_flag_set),
        .irq      (irq_req),
        .sq       (sq_out)
    );

    // R6: a flag strobe only follows a count that is a multiple of the period.
    p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_flag_set |-> ((cnt & $past(mask)) == '0));
    // R2: a zero code leaves the square wave untouched while it is enabled.
    p_code_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0 && sq_en) |=> ($stable(sq_out) && !per_flag_set));
    // R5: with both enables off the square wave cannot toggle high.
    p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_irq_en && !sq_en) |=> (!per_flag_set && !sq_out));
endmodule

// File: tb/rtc_rate_gen_tb_top.sv
`timescale 1ns/1ps
module rtc_rate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb32k_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       per_irq_en = 1'b0;
    logic       sq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       per_flag_set;
    logic       irq_req;
    logic       sq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    logic [14:0] m_cnt = '0;
    logic        e_flag = 1'b0;
    logic        e_irq = 1'b0;
    logic        e_sq = 1'b0;

    always #2.5 clk = ~clk;

    rtc_rate_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tb32k_en     (tb32k_en),
        .rate_sel     (rate_sel),
        .per_irq_en   (per_irq_en),
        .sq_en        (sq_en),
        .irq_ack      (irq_ack),
        .per_flag_set (per_flag_set),
        .irq_req      (irq_req),
        .sq_out       (sq_out)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic        pie;
        logic        sqe;
        logic [15:0] steps;
        logic [3:0]  req;
    } vec_t;

    // Rows run back to back on one count, so each switch also tests R6.
    localparam vec_t VECS [10] = '{
        '{code: 4'd4,  pie: 1'b1, sqe: 1'b0, steps: 16'd40,    req: 4'd3}, // R3 period 8
        '{code: 4'd3,  pie: 1'b1, sqe: 1'b1, steps: 16'd22,    req: 4'd3}, // R3 period 4
        '{code: 4'd5,  pie: 1'b1, sqe: 1'b1, steps: 16'd37,    req: 4'd6}, // R6 switch
        '{code: 4'd1,  pie: 1'b1, sqe: 1'b0, steps: 16'd300,   req: 4'd4}, // R4 alias of 8
        '{code: 4'd8,  pie: 1'b1, sqe: 1'b1, steps: 16'd300,   req: 4'd4}, // R4 twin
        '{code: 4'd2,  pie: 1'b0, sqe: 1'b1, steps: 16'd600,   req: 4'd4}, // R4 alias of 9
        '{code: 4'd0,  pie: 1'b1, sqe: 1'b1, steps: 16'd60,    req: 4'd2}, // R2 off
        '{code: 4'd6,  pie: 1'b0, sqe: 1'b0, steps: 16'd100,   req: 4'd5}, // R5 gated
        '{code: 4'd15, pie: 1'b1, sqe: 1'b1, steps: 16'd16400, req: 4'd3}, // R3 longest
        '{code: 4'd9,  pie: 1'b1, sqe: 1'b1, steps: 16'd600,   req: 4'd4}  // R4 twin of 2
    };

    function automatic int period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 1 << (e - 1);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b count=%0d", tag, act, exp, m_cnt);
        end
    endtask

    // One clock: drive inputs at a falling edge, update the model, and
    // compare at the next falling edge.
    task automatic step(input logic be, input logic ack, input string tag);
        logic tk;
        tb32k_en = be;
        irq_ack  = ack;
        tk = 1'b0;
        if (be) begin
            m_cnt = m_cnt + 15'd1;
            if (rate_sel != 4'd0 && (per_irq_en || sq_en))
                tk = ((int'(m_cnt) % period_of(rate_sel)) == 0);
        end
        e_flag = tk && per_irq_en;
        if (tk && per_irq_en) e_irq = 1'b1;
        else if (ack)         e_irq = 1'b0;
        if (!sq_en)  e_sq = 1'b0;
        else if (tk) e_sq = ~e_sq;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R7 flag"}, per_flag_set, e_flag);
        check({tag, " R8 irq"},  irq_req, e_irq);
        check({tag, " R9 sq"},   sq_out, e_sq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs low under reset, even with strobes and enables active.
        rate_sel = 4'd3; per_irq_en = 1'b1; sq_en = 1'b1; tb32k_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 flag", per_flag_set, 1'b0);
        check("R1 irq",  irq_req, 1'b0);
        check("R1 sq",   sq_out, 1'b0);
        tb32k_en = 1'b0; per_irq_en = 1'b0; sq_en = 1'b0; rate_sel = 4'd0;
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk on one unbroken count.
        for (int v = 0; v < 10; v++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", VECS[v].req, v);
            rate_sel   = VECS[v].code;
            per_irq_en = VECS[v].pie;
            sq_en      = VECS[v].sqe;
            for (int s = 0; s < int'(VECS[v].steps); s++) step(1'b1, 1'b0, tag);
        end

        // R10: idle cycles with no strobe must not advance the phase.
        rate_sel = 4'd3; per_irq_en = 1'b1; sq_en = 1'b1;
        for (int s = 0; s < 7; s++) step(1'b1, 1'b0, "R10 pre");
        for (int s = 0; s < 12; s++) step(1'b0, 1'b0, "R10 idle");
        for (int s = 0; s < 9; s++) step(1'b1, 1'b0, "R10 post");

        // R8: acknowledge away from a tick clears the request.
        while (int'(m_cnt) % 4 != 1) step(1'b1, 1'b0, "R8 align");
        step(1'b1, 1'b1, "R8 ack off tick");
        check("R8 cleared", irq_req, 1'b0);
        // R8: acknowledge on the ticking edge loses to the set.
        while (int'(m_cnt) % 4 != 3) step(1'b1, 1'b0, "R8 align");
        step(1'b1, 1'b1, "R8 ack on tick");
        check("R8 set wins", irq_req, 1'b1);

        // R9: dropping the square-wave enable forces the output low.
        step(1'b1, 1'b0, "R9 run");
        sq_en = 1'b0;
        step(1'b1, 1'b0, "R9 disable");
        check("R9 held low", sq_out, 1'b0);

        // R1: reset in mid-run clears a pending request.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid irq", irq_req, 1'b0);
        check("R1 mid sq",  sq_out, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule